// File: doc/BRIEF.md
# Microengine Debug Execution Access Port

This block lets a host processor control and inspect a small embedded microengine. A simple register-mapped bus slave gives the host an address holding register, a data holding register and a command/status register. Each write to the command register starts exactly one operation. Some operations drive the engine's run state: start, stop and single-step. Others are housekeeping: clear the instruction pipeline, or zero the profile counter. The rest move one word between the data holding register and a location chosen by the address holding register. That location is in instruction memory, in data memory or in a small execution-context register file.

Both memories sit inside the block as plain RAM arrays. The execution core itself is represented by a program counter. It advances by one for every instruction executed, either on each cycle spent running or on each accepted single-step. An execution counter and a profile counter are kept beside it. Reading the command register returns the run-state flags.

Top module: `dbg_exec_port`

## Requirements
- R1: After a synchronous active-low reset, the control register at offset 0x08 reads 0x40800000. That value has the stopped flag (bit 30) set, the pipeline-clean flag (bit 23) set, and the running (bit 31) and cleared (bit 29) flags low. The program counter, the address and data holding registers, the execution count and the profile count all read zero.
- R2: The bus map places the address holding register at byte offset 0x00 and the data holding register at 0x04, and both read back what was written. The control/status register sits at 0x08, the execution count at 0x0C and the profile count at 0x10. Every other offset reads zero.
- R3: Command byte 0x11 writes the data holding register into instruction memory. Command 0x10 loads the data holding register from instruction memory. The word index is the address holding register modulo the instruction memory depth. The result is readable on the following bus cycle.
- R4: Command bytes 0x13 and 0x12 write and read data memory in the same way. The word index is the address holding register modulo the data memory depth.
- R5: Command bytes 0x15 and 0x14 write and read the context register file. Address bits 3:2 select the level and bits 1:0 select the slot, and higher address bits are ignored. Slot 3 of each level is reserved: it reads zero and ignores writes. Slot 0 of level 0 resets to 0xA0000000. Slot 0 of levels 1 and 2 resets to 0x20000080. Every other slot resets to zero.
- R6: Command 0x02 enters the running state and command 0x03 leaves it. While running, the program counter advances by one on every clock edge, starting with the edge after the start command and ending with the edge that accepts the stop command. The status reads 0x80000000 plus the clean and cleared bits.
- R7: Command 0x01 issued while stopped advances the program counter by exactly one, and the engine stays stopped. Issued while running, it has no effect. While stopped and not stepping, the program counter holds.
- R8: The execution count increments once for every instruction executed, whether from a running cycle or an accepted step. The profile count increments on every running cycle only. Command 0x0C zeroes the profile count, and the clear takes priority over a same-cycle increment.
- R9: Command 0x04 sets the pipeline-clean flag (bit 23) and the cleared flag (bit 29). Any executed instruction on a later edge drops the clean flag. A start command drops the cleared flag.
- R10: Only bits 7:0 of a control write form the command. Any other command byte is ignored: it leaves the run state, program counter, counters, flags, holding registers and both memories unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | Write (1) or read (0) for the current access |
| bus_addr | input | 5 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the offset on bus_addr, same cycle |
| core_pc | output | PC_W | Program counter of the modelled execution core |

## Verification
The bench builds the block with a 64-word instruction memory and a 32-word data memory, keeping the 13-bit program counter. With these shallow depths, addresses of 70 and 33 alias onto words 6 and 1, so the modulo indexing rule can be checked with a handful of writes. The context file keeps its four levels, so the address aliasing at bit 4 and the reserved fourth slot are covered too. A behavioural model tracks the program counter, counters and flags through runs, steps while running, profile clears during a run and ignored command bytes.

// File: rtl/dbg_exec_pkg.sv
// Package: shared codes, offsets and reset values for the debug execution port.
// Assumes a 32-bit register bus with 4-byte-aligned register offsets.
package dbg_exec_pkg;

    localparam int BUS_DW = 32;
    localparam int BUS_AW = 5;

    // Register byte offsets on the host bus
    localparam logic [BUS_AW-1:0] OFS_ADDR = 5'h00;
    localparam logic [BUS_AW-1:0] OFS_DATA = 5'h04;
    localparam logic [BUS_AW-1:0] OFS_CTRL = 5'h08;
    localparam logic [BUS_AW-1:0] OFS_XCNT = 5'h0C;
    localparam logic [BUS_AW-1:0] OFS_PROF = 5'h10;

    // Command byte values written to the control register
    typedef enum logic [7:0] {
        CMD_STEP     = 8'h01,
        CMD_START    = 8'h02,
        CMD_STOP     = 8'h03,
        CMD_PIPE_CLR = 8'h04,
        CMD_PROF_CLR = 8'h0C,
        CMD_IMEM_RD  = 8'h10,
        CMD_IMEM_WR  = 8'h11,
        CMD_DMEM_RD  = 8'h12,
        CMD_DMEM_WR  = 8'h13,
        CMD_CTX_RD   = 8'h14,
        CMD_CTX_WR   = 8'h15
    } dbg_cmd_e;

    // Status bit positions in the control register
    localparam int ST_RUN_BIT   = 31;
    localparam int ST_STOP_BIT  = 30;
    localparam int ST_CLR_BIT   = 29;
    localparam int ST_CLEAN_BIT = 23;

    // Context register file geometry
    localparam int CTX_SLOTS      = 4;
    localparam int CTX_SLOT_W     = 2;
    localparam int CTX_LIVE_SLOTS = 3;

    typedef enum logic {
        RS_STOPPED = 1'b0,
        RS_RUNNING = 1'b1
    } run_state_e;

    // True when the command byte names a defined operation
    function automatic logic cmd_is_known(input logic [7:0] c);
        case (c)
            CMD_STEP, CMD_START, CMD_STOP, CMD_PIPE_CLR, CMD_PROF_CLR,
            CMD_IMEM_RD, CMD_IMEM_WR, CMD_DMEM_RD, CMD_DMEM_WR,
            CMD_CTX_RD, CMD_CTX_WR: return 1'b1;
            default:                return 1'b0;
        endcase
    endfunction

    // Reset value of one context slot
    function automatic logic [BUS_DW-1:0] ctx_reset_value(input int lvl, input int slot);
        if (slot != 0)               return '0;
        if (lvl == 0)                return 32'hA000_0000;
        if (lvl == 1 || lvl == 2)    return 32'h2000_0080;
        return '0;
    endfunction

endpackage

// File: rtl/dbg_ram.sv
// Module: single-port word RAM with synchronous write and asynchronous read.
// Assumes DEPTH is a power of two; contents are not reset.
module dbg_ram #(
    parameter int DEPTH = 2048,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Store one word on a write strobe
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/dbg_ctx_regs.sv
// Module: execution-context register file, LEVELS levels of four slots each.
// Assumes LEVELS is a power of two; slot 3 of each level is reserved (reads 0).
module dbg_ctx_regs
    import dbg_exec_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int DW     = 32,
    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1,
    localparam int IDX_W = LVL_W + CTX_SLOT_W,
    localparam int NREG  = LEVELS * CTX_SLOTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);

    logic [DW-1:0] regs [NREG];

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
        for (genvar sl = 0; sl < CTX_SLOTS; sl++) begin : g_slot
            localparam int FLAT = lv * CTX_SLOTS + sl;
            if (sl < CTX_LIVE_SLOTS) begin : g_live
                // Hold one context word, loaded from reset value or host write
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        regs[FLAT] <= ctx_reset_value(lv, sl);
                    end else if (we && idx == IDX_W'(FLAT)) begin
                        regs[FLAT] <= wdata;
                    end
                end
            end else begin : g_rsvd
                assign regs[FLAT] = '0;
            end
        end
    end

    assign rdata = regs[idx];

endmodule

// File: rtl/dbg_run_ctl.sv
// Module: run-state machine of the modelled core with program counter,
// execution and profile counters and the pipeline flags.
// Assumes cmd is only meaningful while cmd_fire is high.
module dbg_run_ctl
    import dbg_exec_pkg::*;
#(
    parameter int PC_W  = 13,
    parameter int CNT_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_fire,
    input  logic [7:0]      cmd,
    output logic            running,
    output logic            clear_seen,
    output logic            pipe_clean,
    output logic [PC_W-1:0] pc,
    output logic [CNT_W-1:0] exec_cnt,
    output logic [CNT_W-1:0] prof_cnt
);

    run_state_e state_q;
    logic       is_start, is_stop, is_step, is_pclr, is_fclr;
    logic       step_go, exec_tick;

    assign is_start  = cmd_fire && (cmd == CMD_START);
    assign is_stop   = cmd_fire && (cmd == CMD_STOP);
    assign is_step   = cmd_fire && (cmd == CMD_STEP);
    assign is_pclr   = cmd_fire && (cmd == CMD_PIPE_CLR);
    assign is_fclr   = cmd_fire && (cmd == CMD_PROF_CLR);
    assign running   = (state_q == RS_RUNNING);
    assign step_go   = is_step && !running;
    assign exec_tick = running || step_go;

    // Run-state transitions on start and stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_STOPPED;
        end else if (is_start) begin
            state_q <= RS_RUNNING;
        end else if (is_stop) begin
            state_q <= RS_STOPPED;
        end
    end

    // Program counter and execution count advance per executed instruction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc       <= '0;
            exec_cnt <= '0;
        end else if (exec_tick) begin
            pc       <= pc + 1'b1;
            exec_cnt <= exec_cnt + 1'b1;
        end
    end

    // Profile count of running cycles, host clear has priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prof_cnt <= '0;
        end else if (is_fclr) begin
            prof_cnt <= '0;
        end else if (running) begin
            prof_cnt <= prof_cnt + 1'b1;
        end
    end

    // Pipeline-clean flag: set by a pipe clear, dropped by execution
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_clean <= 1'b1;
        end else if (is_pclr) begin
            pipe_clean <= 1'b1;
        end else if (exec_tick) begin
            pipe_clean <= 1'b0;
        end
    end

    // Cleared flag: set by a pipe clear, dropped by a start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clear_seen <= 1'b0;
        end else if (is_pclr) begin
            clear_seen <= 1'b1;
        end else if (is_start) begin
            clear_seen <= 1'b0;
        end
    end

endmodule

// File: rtl/dbg_exec_port.sv
// Module: top of the debug execution access port. Decodes host bus
// accesses, holds address/data registers, dispatches commands to the
// memories, the context file and the run controller.
// Assumes one bus access per cycle, reads return data in the same cycle.
module dbg_exec_port
    import dbg_exec_pkg::*;
#(
    parameter int IMEM_DEPTH = 2048,
    parameter int DMEM_DEPTH = 2048,
    parameter int CTX_LEVELS = 4,
    parameter int PC_W       = 13,
    localparam int IMEM_AW   = $clog2(IMEM_DEPTH),
    localparam int DMEM_AW   = $clog2(DMEM_DEPTH),
    localparam int CTX_IW    = ((CTX_LEVELS > 1) ? $clog2(CTX_LEVELS) : 1) + CTX_SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic [PC_W-1:0]   core_pc
);

    logic              wr_sel, cmd_fire;
    logic [7:0]        cmd_code;
    logic [BUS_DW-1:0] addr_q, data_q;
    logic [BUS_DW-1:0] imem_rd, dmem_rd, ctx_rd;
    logic              imem_we, dmem_we, ctx_we;
    logic              running, clear_seen, pipe_clean;
    logic [BUS_DW-1:0] exec_cnt, prof_cnt;
    logic [BUS_DW-1:0] status_word;

    assign wr_sel   = bus_en && bus_we;
    assign cmd_fire = wr_sel && (bus_addr == OFS_CTRL);
    assign cmd_code = bus_wdata[7:0];
    assign imem_we  = cmd_fire && (cmd_code == CMD_IMEM_WR);
    assign dmem_we  = cmd_fire && (cmd_code == CMD_DMEM_WR);
    assign ctx_we   = cmd_fire && (cmd_code == CMD_CTX_WR);

    // Address holding register, written only by the host
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (wr_sel && bus_addr == OFS_ADDR) begin
            addr_q <= bus_wdata;
        end
    end

    // Data holding register, written by the host or by a read command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (wr_sel && bus_addr == OFS_DATA) begin
            data_q <= bus_wdata;
        end else if (cmd_fire) begin
            case (cmd_code)
                CMD_IMEM_RD: data_q <= imem_rd;
                CMD_DMEM_RD: data_q <= dmem_rd;
                CMD_CTX_RD:  data_q <= ctx_rd;
                default:     data_q <= data_q;
            endcase
        end
    end

    dbg_ram #(.DEPTH(IMEM_DEPTH), .DW(BUS_DW)) u_imem (
        .clk   (clk),
        .we    (imem_we),
        .addr  (addr_q[IMEM_AW-1:0]),
        .wdata (data_q),
        .rdata (imem_rd)
    );

    dbg_ram #(.DEPTH(DMEM_DEPTH), .DW(BUS_DW)) u_dmem (
        .clk   (clk),
        .we    (dmem_we),
        .addr  (addr_q[DMEM_AW-1:0]),
        .wdata (data_q),
        .rdata (dmem_rd)
    );

    dbg_ctx_regs #(.LEVELS(CTX_LEVELS), .DW(BUS_DW)) u_ctx (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctx_we),
        .idx   (addr_q[CTX_IW-1:0]),
        .wdata (data_q),
        .rdata (ctx_rd)
    );

    dbg_run_ctl #(.PC_W(PC_W), .CNT_W(BUS_DW)) u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_fire   (cmd_fire),
        .cmd        (cmd_code),
        .running    (running),
        .clear_seen (clear_seen),
        .pipe_clean (pipe_clean),
        .pc         (core_pc),
        .exec_cnt   (exec_cnt),
        .prof_cnt   (prof_cnt)
    );

    // Assemble the status flags read from the control register
    always_comb begin
        status_word               = '0;
        status_word[ST_RUN_BIT]   = running;
        status_word[ST_STOP_BIT]  = !running;
        status_word[ST_CLR_BIT]   = clear_seen;
        status_word[ST_CLEAN_BIT] = pipe_clean;
    end

    // Read-data multiplexer over the register map
    always_comb begin
        case (bus_addr)
            OFS_ADDR: bus_rdata = addr_q;
            OFS_DATA: bus_rdata = data_q;
            OFS_CTRL: bus_rdata = status_word;
            OFS_XCNT: bus_rdata = exec_cnt;
            OFS_PROF: bus_rdata = prof_cnt;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dbg_exec_port_chk.sv
// Module: property checker for the debug execution access port, bound
// to the top. Observes host commands, the run state and the program counter.
module dbg_exec_port_chk
    import dbg_exec_pkg::*;
#(
    parameter int PC_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [7:0]        cmd_byte,
    input logic              running,
    input logic              pipe_clean,
    input logic [PC_W-1:0]   core_pc
);

    logic ctl_wr;
    assign ctl_wr = bus_en && bus_we && (bus_addr == OFS_CTRL);

    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && cmd_byte == 8'h02) |=> running); // R6

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && cmd_byte == 8'h03) |=> !running); // R6

    AST_RUN_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> core_pc == PC_W'($past(core_pc) + 1'b1)); // R6

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && cmd_byte == 8'h01 && !running) |=> (!running && core_pc == PC_W'($past(core_pc) + 1'b1))); // R7

    AST_HALT_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !(ctl_wr && cmd_byte == 8'h01)) |=> $stable(core_pc)); // R7

    AST_PIPE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && cmd_byte == 8'h04) |=> pipe_clean); // R9

    AST_UNKNOWN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !cmd_is_known(cmd_byte)) |=> (running == $past(running))); // R10

endmodule

bind dbg_exec_port dbg_exec_port_chk #(.PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .cmd_byte   (bus_wdata[7:0]),
    .running    (running),
    .pipe_clean (pipe_clean),
    .core_pc    (core_pc)
);

// File: tb/tb_dbg_exec_port.sv
// Bench: behavioural reference model of the debug port, compared each clock.
module tb_dbg_exec_port;

    localparam int IMEM_D = 64;
    localparam int DMEM_D = 32;
    localparam int PC_W   = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [PC_W-1:0] core_pc;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    dbg_exec_port #(.IMEM_DEPTH(IMEM_D), .DMEM_DEPTH(DMEM_D), .PC_W(PC_W)) dut (
        .clk (clk), .rst_n (rst_n), .bus_en (bus_en), .bus_we (bus_we),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .core_pc (core_pc)
    );

    // Reference model state
    bit          m_run, m_clr, m_clean;
    int unsigned m_pc, m_cnt, m_prof;
    bit [31:0]   m_addr, m_data;
    bit [31:0]   m_imem [int];
    bit [31:0]   m_dmem [int];
    bit [31:0]   m_ctx  [16];

    function automatic bit [31:0] ctx_init(int i);
        if (i == 0)           return 32'hA000_0000;
        if (i == 4 || i == 8) return 32'h2000_0080;
        return 32'h0;
    endfunction

    function automatic bit [31:0] model_read(bit [4:0] a);
        case (a)
            5'h00: return m_addr;
            5'h04: return m_data;
            5'h08: return {m_run, !m_run, m_clr, 5'b0, m_clean, 23'b0};
            5'h0C: return m_cnt;
            5'h10: return m_prof;
            default: return 32'h0;
        endcase
    endfunction

    // Model update on each clock edge from the sampled bus inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_clr = 0; m_clean = 1;
            m_pc = 0; m_cnt = 0; m_prof = 0; m_addr = 0; m_data = 0;
            for (int i = 0; i < 16; i++) m_ctx[i] = ctx_init(i);
        end else begin
            bit was_run;
            was_run = m_run;
            if (was_run) begin
                m_pc = (m_pc + 1) % (1 << PC_W);
                m_cnt++; m_prof++; m_clean = 0;
            end
            if (bus_en && bus_we) begin
                case (bus_addr)
                    5'h00: m_addr = bus_wdata;
                    5'h04: m_data = bus_wdata;
                    5'h08: begin
                        case (bus_wdata[7:0])
                            8'h01: if (!was_run) begin
                                       m_pc = (m_pc + 1) % (1 << PC_W);
                                       m_cnt++; m_clean = 0;
                                   end
                            8'h02: begin m_run = 1; m_clr = 0; end
                            8'h03: m_run = 0;
                            8'h04: begin m_clean = 1; m_clr = 1; end
                            8'h0C: m_prof = 0;
                            8'h10: m_data = m_imem[int'(m_addr % IMEM_D)];
                            8'h11: m_imem[int'(m_addr % IMEM_D)] = m_data;
                            8'h12: m_data = m_dmem[int'(m_addr % DMEM_D)];
                            8'h13: m_dmem[int'(m_addr % DMEM_D)] = m_data;
                            8'h14: m_data = m_ctx[m_addr % 16];
                            8'h15: if (m_addr % 4 != 3) m_ctx[m_addr % 16] = m_data;
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input bit [31:0] act, input bit [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Program counter compared with the model on every clock (R6, R7)
    always @(negedge clk) begin
        if (rst_n) check(32'(core_pc), m_pc, "R6_R7 pc");
    end

    task automatic bus_write(input bit [4:0] a, input bit [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic bus_read(input bit [4:0] a, input string tag);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = a;
        #1 check(bus_rdata, model_read(a), tag);
        bus_en = 0;
    endtask

    task automatic read_lit(input bit [4:0] a, input bit [31:0] exp, input string tag);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = a;
        #1 check(bus_rdata, exp, tag);
        bus_en = 0;
    endtask

    task automatic mem_op(input bit [31:0] a, input bit [31:0] d, input bit [7:0] c);
        bus_write(5'h00, a);
        bus_write(5'h04, d);
        bus_write(5'h08, {24'h0, c});
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 20000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        read_lit(5'h08, 32'h4080_0000, "R1 status");
        read_lit(5'h0C, 32'h0, "R1 exec count");
        read_lit(5'h10, 32'h0, "R1 profile");
        read_lit(5'h00, 32'h0, "R1 addr reg");
        read_lit(5'h04, 32'h0, "R1 data reg");

        // R2: holding registers and unmapped offsets
        bus_write(5'h00, 32'h1234_5678);
        read_lit(5'h00, 32'h1234_5678, "R2 addr readback");
        bus_write(5'h04, 32'hCAFE_F00D);
        read_lit(5'h04, 32'hCAFE_F00D, "R2 data readback");
        read_lit(5'h14, 32'h0, "R2 unmapped 0x14");
        read_lit(5'h1C, 32'h0, "R2 unmapped 0x1C");

        // R3: instruction memory write/read with depth aliasing
        mem_op(32'd5, 32'hAAAA_5555, 8'h11);
        mem_op(32'd70, 32'h0000_1234, 8'h11);
        mem_op(32'd5, 32'h0, 8'h10);
        read_lit(5'h04, 32'hAAAA_5555, "R3 imem word 5");
        mem_op(32'd6, 32'h0, 8'h10);
        read_lit(5'h04, 32'h0000_1234, "R3 imem alias 70->6");

        // R4: data memory write/read with depth aliasing
        mem_op(32'd33, 32'h5A5A_0001, 8'h13);
        mem_op(32'd2, 32'h0BAD_BEEF, 8'h13);
        mem_op(32'd1, 32'h0, 8'h12);
        read_lit(5'h04, 32'h5A5A_0001, "R4 dmem alias 33->1");
        mem_op(32'd34, 32'h0, 8'h12);
        read_lit(5'h04, 32'h0BAD_BEEF, "R4 dmem alias 34->2");

        // R5: context file reset values, reserved slot, high address bits
        mem_op(32'h0, 32'h0, 8'h14);
        read_lit(5'h04, 32'hA000_0000, "R5 level0 slot0 reset");
        mem_op(32'h4, 32'h0, 8'h14);
        read_lit(5'h04, 32'h2000_0080, "R5 level1 slot0 reset");
        mem_op(32'h8, 32'h0, 8'h14);
        read_lit(5'h04, 32'h2000_0080, "R5 level2 slot0 reset");
        mem_op(32'hC, 32'h0, 8'h14);
        read_lit(5'h04, 32'h0, "R5 level3 slot0 reset");
        mem_op(32'h3, 32'hFFFF_FFFF, 8'h15);
        mem_op(32'h3, 32'h1111_1111, 8'h14);
        read_lit(5'h04, 32'h0, "R5 reserved slot");
        mem_op(32'hD, 32'h0137_0042, 8'h15);
        mem_op(32'h1D, 32'h0, 8'h14);
        read_lit(5'h04, 32'h0137_0042, "R5 alias 0x1D->0xD");

        // R7: single step while stopped
        bus_write(5'h08, 32'h01);
        read_lit(5'h08, 32'h4000_0000, "R7 stays stopped, clean dropped");
        read_lit(5'h0C, 32'h1, "R8 exec count after step");

        // R9: pipeline clear
        bus_write(5'h08, 32'h04);
        read_lit(5'h08, 32'h6080_0000, "R9 clear and clean flags");

        // R10: unknown commands ignored
        bus_write(5'h08, 32'h05);
        bus_write(5'h08, 32'hFF);
        bus_write(5'h08, 32'h16);
        read_lit(5'h08, 32'h6080_0000, "R10 status unchanged");
        read_lit(5'h0C, 32'h1, "R10 exec count unchanged");
        mem_op(32'd5, 32'h0, 8'h10);
        read_lit(5'h04, 32'hAAAA_5555, "R10 imem unchanged");

        // R6, R10: start with upper data bits set
        bus_write(5'h08, 32'hABCD_0002);
        repeat (6) @(negedge clk);
        read_lit(5'h08, 32'h8000_0000, "R6 running status");
        bus_read(5'h10, "R8 profile while running");
        bus_write(5'h08, 32'h01);
        bus_read(5'h0C, "R7 step while running ignored");
        bus_write(5'h08, 32'h0C);
        bus_read(5'h10, "R8 profile after clear");
        bus_write(5'h08, 32'h04);
        bus_read(5'h08, "R9 clear while running");
        repeat (3) @(negedge clk);
        bus_write(5'h08, 32'h03);
        read_lit(5'h08, 32'h6000_0000, "R6 stopped after stop");
        bus_read(5'h0C, "R8 exec count after run");
        bus_read(5'h10, "R8 profile after run");
        repeat (4) @(negedge clk);
        bus_read(5'h0C, "R7 held while stopped");

        // R8: steps count in exec count but not in profile
        bus_write(5'h08, 32'h01);
        bus_write(5'h08, 32'h01);
        bus_read(5'h0C, "R8 exec count after steps");
        bus_read(5'h10, "R8 profile unchanged by steps");

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule